// File: doc/BRIEF.md
# Multi-Function Pin Mux Controller

The controller owns seven shared I/O pads. Each pad serves one of three sources: a plain general-purpose input or output, an extended chip-select that steers a host SPI transaction to an attached device, or a special function fixed to that pad. Configuration arrives as register-level inputs. These set the direction of each pad, the output data, the chip-select enables, the clock polarity of each select and the special-function enables. The block decides which source drives each pad and returns the pad inputs after synchronizing them.

A special-function enable wins over a chip-select enable, and a chip-select enable wins over the general-purpose function. A pad drives only when its direction bit is 1. Input special functions need the direction bit at 0. Pads 0 to 2 can carry external mux select lines, taken from the same register field as the gain setting. Pad 3 can flag errors. Pad 4 can act as a buffer trigger input. Pad 5 can show buffer-active. Pad 6 can carry the oscillator out or take a sync clock in.

Top module: `pin_mux_ctrl`

## Requirements
- R1: A pad whose direction bit (`pin_dir_i`, 1 = output) is 0 has `pad_oe_o` low and `pad_out_o` low.
- R2: A pad with direction 1, chip-select enable 0 and no special function drives `gpo_data_i` for that pad.
- R3: A pad with direction 1, chip-select enable 1 and no special function drives low while its `cs_req_i` bit is 1, and high (idle) while that bit is 0.
- R4: Special-function bits 0, 1 and 2 of `sf_en_i` make pads 0 to 2 drive `mux_sel_i` bits 0 to 2. This overrides both chip-select and general-purpose output.
- R5: Special-function bit 3 makes pad 3 drive the OR of the five `err_flags_i` bits.
- R6: Special-function bit 5 makes pad 5 drive buffer-active. The pad carries `buf_active_i` when `buf_act_pol_i` is 1 and its inverse when that input is 0.
- R7: Special-function bit 7 makes pad 6 drive `osc_clk_i` combinationally. It takes priority over bit 6.
- R8: Special-function bit 4 (pad 4 trigger input) and bit 6 without bit 7 (pad 6 sync input) hold the pad's output enable low and its output low, whatever the direction bit.
- R9: `gpi_o` is `pad_in_i` delayed by two rising clock edges. It is all zero after reset.
- R10: When bit 4 of `sf_en_i` is set and pad 4 has direction 0, `buf_trig_o` pulses high for one cycle at each rising edge of the synchronized pad 4 input. It stays low while the input is held high.
- R11: When bit 6 of `sf_en_i` is set, bit 7 is clear and pad 6 has direction 0, `sync_clk_sel_o` is 1 and `sync_clk_o` follows `pad_in_i[6]` combinationally. Otherwise both are 0.
- R12: `active_cp_o` returns the clock-phase flag of the lowest-index pad that is owned by a chip-select and has its `cs_req_i` bit set. The flag is 0 when that pad's `cs_pol_i` is 1 (first SCLK edge rising) and 1 when it is 0. The output is 0 when no owned pad is targeted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_dir_i | input | 7 | Pad direction, 1 = output |
| gpo_data_i | input | 7 | General-purpose output data |
| cs_en_i | input | 7 | Chip-select function enable per pad |
| cs_pol_i | input | 7 | Select polarity, 1 = first SCLK edge rising |
| cs_req_i | input | 7 | Transaction currently targets this select |
| sf_en_i | input | 8 | Special-function enables (bit 6 sync in, bit 7 osc out, both on pad 6) |
| mux_sel_i | input | 3 | External mux code shared with gain field |
| err_flags_i | input | 5 | Error bits ORed onto pad 3 |
| buf_active_i | input | 1 | Buffer-active status |
| buf_act_pol_i | input | 1 | Buffer-active output polarity, 1 = active high |
| osc_clk_i | input | 1 | Internal oscillator clock |
| pad_in_i | input | 7 | Pad input levels |
| pad_out_o | output | 7 | Pad output levels |
| pad_oe_o | output | 7 | Pad output enables |
| gpi_o | output | 7 | Synchronized pad inputs |
| buf_trig_o | output | 1 | Buffer trigger rising-edge pulse |
| sync_clk_o | output | 1 | External sync clock from pad 6 |
| sync_clk_sel_o | output | 1 | Sync clock input selected |
| active_cp_o | output | 1 | Clock-phase flag of the targeted select |

## Verification
Pad outputs, `sync_clk_o`, `sync_clk_sel_o` and `active_cp_o` are combinational and are due in the same cycle as the input that changes them. `gpi_o` lags the pad by two rising edges. `buf_trig_o` rises with the second-stage synchronizer and lasts until the next edge. The bench changes inputs just after each falling edge and checks at the next falling edge. It keeps a queue of pad samples, one pushed at each rising edge after reset, and reads the delayed expectations from fixed depths of that queue. One phase holds pad 4 high over many cycles to show that only a single trigger pulse appears.

// File: rtl/pin_mux_pkg.sv
`timescale 1ns/1ps
package pin_mux_pkg;
  localparam int unsigned NUM_PINS = 7;
  localparam int unsigned SF_W     = 8;
  localparam int unsigned MUX_W    = 3;
  localparam int unsigned ERR_W    = 5;
  localparam int unsigned PIN_ERR  = 3;
  localparam int unsigned PIN_TRIG = 4;
  localparam int unsigned PIN_BUF  = 5;
  localparam int unsigned PIN_CLK  = 6;
  localparam int unsigned SF_SYNC  = 6;
  localparam int unsigned SF_OSC   = 7;

  typedef enum logic [1:0] {
    SRC_HIZ  = 2'd0,
    SRC_GPIO = 2'd1,
    SRC_CS   = 2'd2,
    SRC_SF   = 2'd3
  } pin_src_e;
endpackage

// File: rtl/pin_in_sync.sv
`timescale 1ns/1ps
module pin_in_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pin_src_sel.sv
`timescale 1ns/1ps
module pin_src_sel
  import pin_mux_pkg::*;
(
  input  logic     dir_i,
  input  logic     cs_en_i,
  input  logic     sf_out_i,
  input  logic     sf_in_i,
  output pin_src_e src_o
);
  // input special function and input direction both release the pad
  always_comb begin
    if (sf_in_i || !dir_i) src_o = SRC_HIZ;
    else if (sf_out_i)     src_o = SRC_SF;
    else if (cs_en_i)      src_o = SRC_CS;
    else                   src_o = SRC_GPIO;
  end
endmodule

// File: rtl/cs_cp_pick.sv
`timescale 1ns/1ps
module cs_cp_pick #(
  parameter int unsigned N = 7
) (
  input  logic [N-1:0] owned_i,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] pol_i,
  output logic         cp_o
);
  logic hit;

  always_comb begin
    cp_o = 1'b0;
    hit  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!hit && owned_i[i] && req_i[i]) begin
        cp_o = ~pol_i[i];
        hit  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pin_mux_ctrl.sv
`timescale 1ns/1ps
module pin_mux_ctrl
  import pin_mux_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_dir_i,
  input  logic [NUM_PINS-1:0] gpo_data_i,
  input  logic [NUM_PINS-1:0] cs_en_i,
  input  logic [NUM_PINS-1:0] cs_pol_i,
  input  logic [NUM_PINS-1:0] cs_req_i,
  input  logic [SF_W-1:0]     sf_en_i,
  input  logic [MUX_W-1:0]    mux_sel_i,
  input  logic [ERR_W-1:0]    err_flags_i,
  input  logic                buf_active_i,
  input  logic                buf_act_pol_i,
  input  logic                osc_clk_i,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] gpi_o,
  output logic                buf_trig_o,
  output logic                sync_clk_o,
  output logic                sync_clk_sel_o,
  output logic                active_cp_o
);
  logic [NUM_PINS-1:0] sf_out_en, sf_in_en, sf_val, cs_owned, gpi_sync;
  logic                err_any, buf_lvl, trig_prev_q, trig_path_en;

  assign err_any = |err_flags_i;
  assign buf_lvl = buf_active_i ~^ buf_act_pol_i;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pin_src_e src;
    logic     out_b, oe_b;

    if (p < MUX_W) begin : g_mux
      assign sf_out_en[p] = sf_en_i[p];
      assign sf_in_en[p]  = 1'b0;
      assign sf_val[p]    = mux_sel_i[p];
    end else if (p == PIN_ERR) begin : g_err
      assign sf_out_en[p] = sf_en_i[p];
      assign sf_in_en[p]  = 1'b0;
      assign sf_val[p]    = err_any;
    end else if (p == PIN_TRIG) begin : g_trig
      assign sf_out_en[p] = 1'b0;
      assign sf_in_en[p]  = sf_en_i[p];
      assign sf_val[p]    = 1'b0;
    end else if (p == PIN_BUF) begin : g_buf
      assign sf_out_en[p] = sf_en_i[p];
      assign sf_in_en[p]  = 1'b0;
      assign sf_val[p]    = buf_lvl;
    end else begin : g_clk
      assign sf_out_en[p] = sf_en_i[SF_OSC];
      assign sf_in_en[p]  = sf_en_i[SF_SYNC] & ~sf_en_i[SF_OSC];
      assign sf_val[p]    = osc_clk_i;
    end

    pin_src_sel u_sel (
      .dir_i    (pin_dir_i[p]),
      .cs_en_i  (cs_en_i[p]),
      .sf_out_i (sf_out_en[p]),
      .sf_in_i  (sf_in_en[p]),
      .src_o    (src)
    );

    always_comb begin
      oe_b  = 1'b1;
      out_b = 1'b0;
      unique case (src)
        SRC_SF:   out_b = sf_val[p];
        SRC_CS:   out_b = ~cs_req_i[p];  // select is active low, idles high
        SRC_GPIO: out_b = gpo_data_i[p];
        default:  oe_b  = 1'b0;
      endcase
    end

    assign pad_out_o[p] = out_b;
    assign pad_oe_o[p]  = oe_b;
    assign cs_owned[p]  = (src == SRC_CS);
  end

  pin_in_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (gpi_sync)
  );

  assign gpi_o = gpi_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_prev_q <= 1'b0;
    else         trig_prev_q <= gpi_sync[PIN_TRIG];
  end

  assign trig_path_en   = sf_in_en[PIN_TRIG] & ~pin_dir_i[PIN_TRIG];
  assign buf_trig_o     = trig_path_en & gpi_sync[PIN_TRIG] & ~trig_prev_q;
  assign sync_clk_sel_o = sf_in_en[PIN_CLK] & ~pin_dir_i[PIN_CLK];
  assign sync_clk_o     = sync_clk_sel_o & pad_in_i[PIN_CLK];

  cs_cp_pick #(
    .N (NUM_PINS)
  ) u_cp (
    .owned_i (cs_owned),
    .req_i   (cs_req_i),
    .pol_i   (cs_pol_i),
    .cp_o    (active_cp_o)
  );
endmodule

// File: rtl/pin_mux_chk.sv
`timescale 1ns/1ps
module pin_mux_chk
  import pin_mux_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] pin_dir_i,
  input logic [NUM_PINS-1:0] cs_en_i,
  input logic [NUM_PINS-1:0] cs_req_i,
  input logic [SF_W-1:0]     sf_en_i,
  input logic                osc_clk_i,
  input logic [NUM_PINS-1:0] pad_in_i,
  input logic [NUM_PINS-1:0] pad_out_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] gpi_o,
  input logic                buf_trig_o,
  input logic                sync_clk_o,
  input logic                sync_clk_sel_o
);
  logic [1:0] since_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_rst_q <= '0;
    else if (since_rst_q != 3) since_rst_q <= since_rst_q + 2'd1;
  end

  // R1
  oe_needs_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~pin_dir_i) == '0);

  // R3
  cs_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_en_i[1] && pin_dir_i[1] && !sf_en_i[1] && !cs_req_i[1]) |-> pad_out_o[1]);

  // R7
  osc_drives_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sf_en_i[SF_OSC] && pin_dir_i[PIN_CLK]) |->
      (pad_oe_o[PIN_CLK] && pad_out_o[PIN_CLK] == osc_clk_i));

  // R8
  trig_pad_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sf_en_i[PIN_TRIG] |-> !pad_oe_o[PIN_TRIG]);

  if (SYNC_STAGES == 2) begin : g_lat
    // R9
    gpi_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst_q >= 2) |-> gpi_o == $past(pad_in_i, 2));
  end

  // R10
  trig_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_trig_o |=> !buf_trig_o);

  // R11
  sync_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_clk_sel_o |-> !sync_clk_o);
endmodule

bind pin_mux_ctrl pin_mux_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/pin_mux_ctrl_tb.sv
`timescale 1ns/1ps
module pin_mux_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] dir = '0, gpo = '0, cs_en = '0, cs_pol = '0, cs_req = '0, pad_in = '0;
  logic [7:0] sf = '0;
  logic [2:0] mux = '0;
  logic [4:0] err = '0;
  logic       buf_act = 1'b0, buf_pol = 1'b0, osc = 1'b0;
  logic [6:0] pad_out, pad_oe, gpi;
  logic       trig, sclk, sclk_sel, cp;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  logic [6:0] hist [$];

  always #4 clk = ~clk;

  pin_mux_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_dir_i(dir), .gpo_data_i(gpo),
    .cs_en_i(cs_en), .cs_pol_i(cs_pol), .cs_req_i(cs_req), .sf_en_i(sf),
    .mux_sel_i(mux), .err_flags_i(err), .buf_active_i(buf_act),
    .buf_act_pol_i(buf_pol), .osc_clk_i(osc), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .gpi_o(gpi), .buf_trig_o(trig),
    .sync_clk_o(sclk), .sync_clk_sel_o(sclk_sel), .active_cp_o(cp)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      hist.push_front(pad_in);
      if (hist.size() > 4) void'(hist.pop_back());
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic check_all();
    logic [6:0] e_gpi;
    logic s2, s3, e_trig, e_sel, e_cp, found;
    e_gpi = (hist.size() > 1) ? hist[1] : 7'd0;
    s2    = (hist.size() > 1) ? hist[1][4] : 1'b0;
    s3    = (hist.size() > 2) ? hist[2][4] : 1'b0;
    chk("R9 gpi", gpi, e_gpi);
    e_trig = sf[4] & ~dir[4] & s2 & ~s3;
    chk("R10 trigger", trig, e_trig);
    e_sel = sf[6] & ~sf[7] & ~dir[6];
    chk("R11 sync select", sclk_sel, e_sel);
    chk("R11 sync clock", sclk, e_sel & pad_in[6]);
    e_cp = 1'b0;
    found = 1'b0;
    for (int i = 0; i < 7; i++) begin
      logic e_oe, e_out, sfo, sfi;
      string tag;
      sfo = (i == 6) ? sf[7] : (i == 4) ? 1'b0 : sf[i];
      sfi = (i == 4) ? sf[4] : (i == 6) ? (sf[6] & ~sf[7]) : 1'b0;
      if (sfi) begin
        e_oe = 0; e_out = 0; tag = "R8";
      end else if (!dir[i]) begin
        e_oe = 0; e_out = 0; tag = "R1";
      end else if (sfo) begin
        e_oe = 1;
        if (i < 3)       begin e_out = mux[i]; tag = "R4"; end
        else if (i == 3) begin e_out = |err; tag = "R5"; end
        else if (i == 5) begin e_out = buf_pol ? buf_act : ~buf_act; tag = "R6"; end
        else             begin e_out = osc; tag = "R7"; end
      end else if (cs_en[i]) begin
        e_oe = 1; e_out = ~cs_req[i]; tag = "R3";
        if (!found && cs_req[i]) begin
          found = 1'b1;
          e_cp  = ~cs_pol[i];
        end
      end else begin
        e_oe = 1; e_out = gpo[i]; tag = "R2";
      end
      chk($sformatf("%s pad%0d", tag, i), {pad_oe[i], pad_out[i]}, {e_oe, e_out});
    end
    chk("R12 clock phase", cp, e_cp);
  endtask

  task automatic run_phase(input int n,
                           input logic [6:0] d_and, input logic [6:0] d_or,
                           input logic [6:0] c_and, input logic [6:0] c_or,
                           input logic [7:0] s_and, input logic [7:0] s_or,
                           input bit hold4);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cyc++;
      check_all();
      dir     = (7'($urandom) & d_and) | d_or;
      cs_en   = (7'($urandom) & c_and) | c_or;
      sf      = (8'($urandom) & s_and) | s_or;
      gpo     = 7'($urandom);
      cs_pol  = 7'($urandom);
      cs_req  = 7'($urandom);
      mux     = 3'($urandom);
      err     = 5'($urandom & $urandom & $urandom);
      buf_act = 1'($urandom);
      buf_pol = 1'($urandom);
      osc     = 1'($urandom);
      pad_in  = 7'($urandom);
      if (hold4) pad_in[4] = ((k % 16) < 9);  // long high hold, short low gap
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset gpi", gpi, 0);
    chk("R10 reset trigger", trig, 0);
    chk("R1 reset pad enables", pad_oe, 0);
    rst_n = 1'b1;
    run_phase(200, 7'h7F, 7'h00, 7'h7F, 7'h00, 8'hFF, 8'h00, 1'b0); // mixed
    run_phase(200, 7'h00, 7'h7F, 7'h7F, 7'h00, 8'h00, 8'h00, 1'b0); // R2 R3
    run_phase(200, 7'h00, 7'h7F, 7'h7F, 7'h00, 8'hFF, 8'hAF, 1'b0); // R4-R7
    run_phase(200, 7'h00, 7'h00, 7'h7F, 7'h00, 8'hFF, 8'h00, 1'b0); // R1 R8
    run_phase(200, 7'h6F, 7'h00, 7'h7F, 7'h00, 8'hFF, 8'h10, 1'b1); // R10
    run_phase(200, 7'h3F, 7'h00, 7'h7F, 7'h00, 8'h7F, 8'h40, 1'b0); // R11
    run_phase(200, 7'h00, 7'h7F, 7'h7F, 7'h00, 8'h7F, 8'h50, 1'b0); // R8
    run_phase(200, 7'h00, 7'h7F, 7'h00, 7'h7F, 8'h00, 8'h00, 1'b0); // R12
    @(negedge clk);
    cyc++;
    check_all();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule